// File: doc/BRIEF.md
# Bang-Bang Sampling Delay Tracker

This block steers the sampling delay of one receive bitslice so that its data sample stays in the middle of the incoming eye. Every cycle it receives two samples of the line, one taken on the positive sampling phase and one on the negative. One of the two is treated as the edge sample and the other as the data sample. An early/late comparison of the pair gives a direction. The block moves a tap counter by one tap in that direction, at a fixed pace, so that each move can settle before the next one.

Lock is declared once the applied steps keep changing direction, which is the dither expected around the eye centre. If a step carries the counter to either end of its range, the block raises a one-cycle overflow or underflow pulse. It then ignores the phase decisions and walks the counter one full unit interval back toward the middle, one tap per cycle. Lock stays low during this walk, and tracking then resumes from scratch. Repeated boundary hits caused by drift are reduced to a single pulse per kind until lock is regained.

Top module: `tap_tracker`

## Requirements
- R1: Each decision compares the edge sample with the data sample. Equal samples request a one-tap increase and unequal samples request a one-tap decrease.
- R2: With IS_SLAVE=0 the data sample is `samp_n` and the edge sample is `samp_p`; with IS_SLAVE=1 the roles are swapped. `center_o` presents the data sample captured at the previous clock edge.
- R3: While tracking, the tap value changes only on every UPD_INTERVAL-th cycle, counted from reset release or from the end of a forced move. The only decision applied is the one present in that last cycle of the interval. The tap value never exceeds TAP_MAX.
- R4: `inc_o` or `dec_o` is high for exactly the cycles in which `tap_o` has just risen or fallen by one. The two are never high together.
- R5: `locked_o` rises once LOCK_REVERSALS consecutive applied steps have each reversed the direction of the step before. After that it stays high until a range boundary is reached.
- R6: A step that brings the tap to TAP_MAX starts a forced move of HOP_TAPS one-per-cycle decrements. A step that brings it to 0 starts HOP_TAPS increments. Samples are ignored and `locked_o` is low throughout the move. Afterwards tracking restarts with a fresh interval and a cleared reversal count.
- R7: The step that reaches TAP_MAX produces a one-cycle `ovf_o` pulse in the cycle the tap shows TAP_MAX, and the step that reaches 0 produces a one-cycle `unf_o` pulse in the cycle the tap shows 0. After a pulse, further events of that kind produce no pulse until `locked_o` has risen again.
- R8: Synchronous active-low reset sets the tap to TAP_MAX/2 and clears lock, the strobes and the pulses. Both pulse kinds are enabled after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_p | input | 1 | Sample taken on the positive sampling phase |
| samp_n | input | 1 | Sample taken on the negative sampling phase |
| tap_o | output | $clog2(TAP_MAX+1) | Current delay tap |
| inc_o | output | 1 | Tap was just incremented |
| dec_o | output | 1 | Tap was just decremented |
| locked_o | output | 1 | Tracking is locked on the eye centre |
| ovf_o | output | 1 | Single-cycle upper boundary event |
| unf_o | output | 1 | Single-cycle lower boundary event |
| center_o | output | 1 | Registered data sample |

## Verification
The main instance uses the master role with TAP_MAX=20, UPD_INTERVAL=4 and HOP_TAPS=10. With these values both range ends and the repeated forced moves can be reached within a few hundred cycles. This lets the bench test repeated boundary hits before and after lock is regained, and the filtering of the events. A second instance keeps the default parameters (100 taps, 8-cycle pacing, 50-tap move) with the slave role, to check the swapped sample roles and the default pacing.

// File: rtl/tap_tracker_pkg.sv
// Shared types for the sampling delay tracker.
package tap_tracker_pkg;
    // Operating mode of the tap controller.
    typedef enum logic {
        TRK_FOLLOW = 1'b0,  // paced phase tracking
        TRK_HOP    = 1'b1   // forced one-UI move after a boundary
    } trk_mode_e;
endpackage

// File: rtl/tt_phase_detect.sv
// Early/late decision for one bitslice.
// Picks which of the two samples is the edge sample and which is the data
// sample, according to the bitslice role. Requests an increase when they
// match and a decrease when they differ. Also registers the data sample.
// Assumes both samples arrive aligned to clk.
module tt_phase_detect #(
    parameter bit IS_SLAVE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic samp_p,
    input  logic samp_n,
    output logic want_up,
    output logic center_o
);
    logic edge_s;
    logic data_s;

    // Role selection: master uses n as data, slave uses p as data.
    generate
        if (IS_SLAVE) begin : g_slave
            assign edge_s = samp_n;
            assign data_s = samp_p;
        end else begin : g_master
            assign edge_s = samp_p;
            assign data_s = samp_n;
        end
    endgenerate

    // Decision: same value on both samples means the clock is early.
    assign want_up = (edge_s == data_s);

    // Register the data sample for the downstream data path.
    always_ff @(posedge clk) begin
        if (!rst_n) center_o <= 1'b0;
        else        center_o <= data_s;
    end
endmodule

// File: rtl/tt_tap_track.sv
// Paced tap counter with lock detection and forced UI moves.
// Applies one step every UPD_INTERVAL cycles while tracking. It declares
// lock after LOCK_REVERSALS direction reversals in a row, and on reaching
// either end of the range it moves HOP_TAPS taps away from that end.
// Assumes 1 <= HOP_TAPS < TAP_MAX and UPD_INTERVAL >= 2.
module tt_tap_track
    import tap_tracker_pkg::*;
#(
    parameter int TAP_MAX        = 100,
    parameter int UPD_INTERVAL   = 8,
    parameter int HOP_TAPS       = 50,
    parameter int LOCK_REVERSALS = 4,
    localparam int TAP_W = $clog2(TAP_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             want_up,
    output logic [TAP_W-1:0] tap_o,
    output logic             inc_o,
    output logic             dec_o,
    output logic             locked_o,
    output logic             hit_top,
    output logic             hit_bottom,
    output logic             lock_gain
);
    localparam int CNT_W = $clog2(UPD_INTERVAL);
    localparam int HOP_W = $clog2(HOP_TAPS + 1);
    localparam int REV_W = $clog2(LOCK_REVERSALS + 1);

    trk_mode_e        mode_q;
    logic [CNT_W-1:0] cnt_q;
    logic [HOP_W-1:0] hop_left_q;
    logic             hop_up_q;
    logic [REV_W-1:0] rev_q;
    logic [REV_W-1:0] rev_next;
    logic             last_up_q;
    logic             have_last_q;
    logic             apply;
    logic             reversal;

    // Step strobe: the last cycle of a pacing interval while tracking.
    assign apply = (mode_q == TRK_FOLLOW) && (cnt_q == CNT_W'(UPD_INTERVAL - 1));

    // Boundary detection on the step that is about to be applied.
    assign hit_top    = apply && want_up  && (tap_o == TAP_W'(TAP_MAX - 1));
    assign hit_bottom = apply && !want_up && (tap_o == TAP_W'(1));

    // Reversal counting for the lock decision.
    assign reversal = have_last_q && (want_up != last_up_q);
    always_comb begin
        if (!reversal)                               rev_next = '0;
        else if (rev_q == REV_W'(LOCK_REVERSALS))    rev_next = rev_q;
        else                                         rev_next = rev_q + 1'b1;
    end
    assign lock_gain = apply && !locked_o && !hit_top && !hit_bottom
                       && (rev_next == REV_W'(LOCK_REVERSALS));

    // Main sequencer: paced tracking, forced moves, lock flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q      <= TRK_FOLLOW;
            cnt_q       <= '0;
            tap_o       <= TAP_W'(TAP_MAX / 2);
            inc_o       <= 1'b0;
            dec_o       <= 1'b0;
            locked_o    <= 1'b0;
            hop_left_q  <= '0;
            hop_up_q    <= 1'b0;
            rev_q       <= '0;
            last_up_q   <= 1'b0;
            have_last_q <= 1'b0;
        end else begin
            inc_o <= 1'b0;
            dec_o <= 1'b0;
            case (mode_q)
                TRK_FOLLOW: begin
                    if (apply) begin
                        cnt_q       <= '0;
                        tap_o       <= want_up ? tap_o + 1'b1 : tap_o - 1'b1;
                        inc_o       <= want_up;
                        dec_o       <= !want_up;
                        last_up_q   <= want_up;
                        have_last_q <= 1'b1;
                        rev_q       <= rev_next;
                        if (lock_gain) locked_o <= 1'b1;
                        if (hit_top || hit_bottom) begin
                            mode_q     <= TRK_HOP;
                            hop_up_q   <= hit_bottom;
                            hop_left_q <= HOP_W'(HOP_TAPS);
                            locked_o   <= 1'b0;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                TRK_HOP: begin
                    tap_o      <= hop_up_q ? tap_o + 1'b1 : tap_o - 1'b1;
                    inc_o      <= hop_up_q;
                    dec_o      <= !hop_up_q;
                    hop_left_q <= hop_left_q - 1'b1;
                    if (hop_left_q == HOP_W'(1)) begin
                        mode_q      <= TRK_FOLLOW;
                        cnt_q       <= '0;
                        rev_q       <= '0;
                        have_last_q <= 1'b0;
                    end
                end
                default: mode_q <= TRK_FOLLOW;
            endcase
        end
    end

    // R3: tap stays inside its range
    a_r3_tap_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        tap_o <= TAP_W'(TAP_MAX));
    // R4: strobes are exclusive
    a_r4_strobe_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(inc_o && dec_o));
    // R4: an increment strobe matches a one-tap rise
    a_r4_inc_matches_tap: assert property (@(posedge clk) disable iff (!rst_n)
        inc_o |-> (tap_o == $past(tap_o) + 1'b1));
    // R4: a decrement strobe matches a one-tap fall
    a_r4_dec_matches_tap: assert property (@(posedge clk) disable iff (!rst_n)
        dec_o |-> (tap_o == $past(tap_o) - 1'b1));
    // R6: no lock during a forced move
    a_r6_unlocked_in_hop: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == TRK_HOP) |-> !locked_o);
    // R5: lock persists unless a boundary is hit
    a_r5_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && !hit_top && !hit_bottom) |=> locked_o);
endmodule

// File: rtl/tt_event_filter.sv
// Reduces repeated boundary events to one pulse per kind.
// A pulse disables further pulses of its kind until lock is gained again.
// Assumes lock_gain is never high in the same cycle as a boundary event.
module tt_event_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_top,
    input  logic hit_bottom,
    input  logic lock_gain,
    output logic ovf_o,
    output logic unf_o
);
    logic top_armed_q;
    logic bottom_armed_q;

    // Pulse generation and per-kind arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_o          <= 1'b0;
            unf_o          <= 1'b0;
            top_armed_q    <= 1'b1;
            bottom_armed_q <= 1'b1;
        end else begin
            ovf_o <= hit_top && top_armed_q;
            unf_o <= hit_bottom && bottom_armed_q;
            if (lock_gain) begin
                top_armed_q    <= 1'b1;
                bottom_armed_q <= 1'b1;
            end else begin
                if (hit_top)    top_armed_q    <= 1'b0;
                if (hit_bottom) bottom_armed_q <= 1'b0;
            end
        end
    end

    // R7: overflow pulse lasts one cycle
    a_r7_ovf_single: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> !ovf_o);
    // R7: underflow pulse lasts one cycle
    a_r7_unf_single: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |=> !unf_o);
    // R7: a disarmed kind stays silent
    a_r7_disarmed_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (!top_armed_q && !lock_gain) |=> !ovf_o);
endmodule

// File: rtl/tap_tracker.sv
// Top of the sampling delay tracker for one bitslice.
// Joins the phase decision, the paced tap controller and the event filter.
// Assumes the samples come from an external delay line driven by tap_o.
module tap_tracker #(
    parameter bit IS_SLAVE       = 1'b0,
    parameter int TAP_MAX        = 100,
    parameter int UPD_INTERVAL   = 8,
    parameter int HOP_TAPS       = 50,
    parameter int LOCK_REVERSALS = 4,
    localparam int TAP_W = $clog2(TAP_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             samp_p,
    input  logic             samp_n,
    output logic [TAP_W-1:0] tap_o,
    output logic             inc_o,
    output logic             dec_o,
    output logic             locked_o,
    output logic             ovf_o,
    output logic             unf_o,
    output logic             center_o
);
    logic want_up;
    logic hit_top;
    logic hit_bottom;
    logic lock_gain;

    tt_phase_detect #(.IS_SLAVE(IS_SLAVE)) u_pd (
        .clk      (clk),
        .rst_n    (rst_n),
        .samp_p   (samp_p),
        .samp_n   (samp_n),
        .want_up  (want_up),
        .center_o (center_o)
    );

    tt_tap_track #(
        .TAP_MAX        (TAP_MAX),
        .UPD_INTERVAL   (UPD_INTERVAL),
        .HOP_TAPS       (HOP_TAPS),
        .LOCK_REVERSALS (LOCK_REVERSALS)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .want_up    (want_up),
        .tap_o      (tap_o),
        .inc_o      (inc_o),
        .dec_o      (dec_o),
        .locked_o   (locked_o),
        .hit_top    (hit_top),
        .hit_bottom (hit_bottom),
        .lock_gain  (lock_gain)
    );

    tt_event_filter u_filt (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_top    (hit_top),
        .hit_bottom (hit_bottom),
        .lock_gain  (lock_gain),
        .ovf_o      (ovf_o),
        .unf_o      (unf_o)
    );

    // R7: the two pulse kinds never coincide
    a_r7_kinds_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_o && unf_o));
endmodule

// File: tb/tap_tracker_bench.sv
// Bench: behavioural reference model of the master instance, compared every cycle.
module tap_tracker_bench;
    localparam int TM  = 20;
    localparam int IV  = 4;
    localparam int HOP = 10;
    localparam int LR  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic samp_p = 1'b0;
    logic samp_n = 1'b0;

    logic [4:0] tap;
    logic inc, dec, lck, ovf, unf, ctr;
    logic [6:0] s_tap;
    logic s_inc, s_dec, s_lck, s_ovf, s_unf, s_ctr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int ovf_seen = 0;
    int unf_seen = 0;

    // reference model state
    int m_tap = TM / 2, m_cnt = 0, m_hop = 0, m_left = 0, m_hup = 0;
    int m_lock = 0, m_rev = 0, m_last = 0, m_arm_o = 1, m_arm_u = 1;
    int m_inc = 0, m_dec = 0, m_ovf = 0, m_unf = 0, m_ctr = 0;

    always #2 clk = ~clk;

    tap_tracker #(.IS_SLAVE(1'b0), .TAP_MAX(TM), .UPD_INTERVAL(IV),
                  .HOP_TAPS(HOP), .LOCK_REVERSALS(LR)) u_tap_tracker (
        .clk(clk), .rst_n(rst_n), .samp_p(samp_p), .samp_n(samp_n),
        .tap_o(tap), .inc_o(inc), .dec_o(dec), .locked_o(lck),
        .ovf_o(ovf), .unf_o(unf), .center_o(ctr));

    tap_tracker #(.IS_SLAVE(1'b1)) u_tap_tracker_slave (
        .clk(clk), .rst_n(rst_n), .samp_p(samp_p), .samp_n(samp_n),
        .tap_o(s_tap), .inc_o(s_inc), .dec_o(s_dec), .locked_o(s_lck),
        .ovf_o(s_ovf), .unf_o(s_unf), .center_o(s_ctr));

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_tap = TM / 2; m_cnt = 0; m_hop = 0; m_left = 0; m_hup = 0;
            m_lock = 0; m_rev = 0; m_last = 0; m_arm_o = 1; m_arm_u = 1;
            m_inc = 0; m_dec = 0; m_ovf = 0; m_unf = 0; m_ctr = 0;
        end else begin
            m_inc = 0; m_dec = 0; m_ovf = 0; m_unf = 0;
            m_ctr = int'(samp_n);
            if (m_hop != 0) begin
                m_tap += (m_hup != 0) ? 1 : -1;
                m_inc = m_hup; m_dec = (m_hup == 0);
                m_left--;
                if (m_left == 0) begin
                    m_hop = 0; m_cnt = 0; m_rev = 0; m_last = 0;
                end
            end else if (m_cnt == IV - 1) begin
                int dir;
                m_cnt = 0;
                dir = (samp_p == samp_n) ? 1 : -1;
                m_tap += dir;
                m_inc = (dir == 1); m_dec = (dir == -1);
                if (m_last != 0) m_rev = (dir != m_last) ? m_rev + 1 : 0;
                m_last = dir;
                if (m_tap == TM || m_tap == 0) begin
                    m_hop = 1; m_left = HOP; m_hup = (m_tap == 0); m_lock = 0;
                    if (m_tap == TM) begin m_ovf = m_arm_o; m_arm_o = 0; end
                    else             begin m_unf = m_arm_u; m_arm_u = 0; end
                end else if (m_lock == 0 && m_rev >= LR) begin
                    m_lock = 1; m_arm_o = 1; m_arm_u = 1;
                end
            end else begin
                m_cnt++;
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check("R3 tap", int'(tap), m_tap);
            check("R4 inc", int'(inc), m_inc);
            check("R4 dec", int'(dec), m_dec);
            check("R5 lock", int'(lck), m_lock);
            check("R7 ovf", int'(ovf), m_ovf);
            check("R7 unf", int'(unf), m_unf);
            check("R2 center", int'(ctr), m_ctr);
            if (ovf) ovf_seen++;
            if (unf) unf_seen++;
        end
    end

    task automatic drive(input logic p, input logic n, input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            samp_p = p; samp_n = n;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state
        check("R8 reset tap", int'(tap), TM / 2);
        check("R8 reset lock", int'(lck), 0);
        check("R8 reset slave tap", int'(s_tap), 50);
        check("R8 reset strobes", int'(inc | dec | ovf | unf), 0);
        @(negedge clk);
        rst_n = 1'b1; samp_p = 1'b1; samp_n = 1'b0;
        @(negedge clk);
        // R2: master presents n, slave presents p
        check("R2 master center", int'(ctr), 0);
        check("R2 slave center", int'(s_ctr), 1);
        samp_p = 1'b1; samp_n = 1'b1;
        drive(1'b1, 1'b1, 6);
        @(negedge clk);
        // R1, R3: slave applies its first step on the 8th edge, upward
        check("R1 slave first step", int'(s_tap), 51);
        check("R4 slave inc strobe", int'(s_inc), 1);
        // R6, R7: climb to the top twice; only the first hit pulses
        drive(1'b1, 1'b1, 112);
        check("R7 one ovf before relock", ovf_seen, 1);
        // R5: alternating decisions bring lock
        for (int b = 0; b < 7; b++) begin
            drive(1'b1, 1'b1, IV);
            drive(1'b1, 1'b0, IV);
        end
        check("R5 locked after reversals", int'(lck), 1);
        // R3: only the last decision of each interval counts
        for (int b = 0; b < 6; b++) begin
            drive(1'b0, 1'b1, IV - 1);
            drive(1'b0, 1'b0, 1);
        end
        // R7: after relock a new top hit pulses again
        drive(1'b1, 1'b1, 80);
        check("R7 ovf rearmed by lock", ovf_seen, 2);
        // R6: descend to the bottom twice; only one underflow pulse
        drive(1'b0, 1'b1, 240);
        check("R7 one unf before relock", unf_seen, 1);
        check("R6 no lock after hops", int'(lck), 0);
        drive(1'b0, 1'b0, 4);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule